// File: doc/BRIEF.md
# Line Overhead Byte Inserter

This block sits in a byte-serial SONET/SDH transmit path and replaces chosen line overhead bytes as they stream past. Three slot strobes, produced by an external frame position decoder, mark the synchronisation status byte, the orderwire byte and the reserved line overhead bytes. For each marked byte the block picks one of several sources: the incoming byte, a configuration value, a byte from the serial overhead port, or a fixed stuff pattern. Every other byte goes through untouched. Every byte, substituted or not, leaves through one output register, so the latency is one clock throughout.

The synchronisation status byte and the orderwire byte each have an enable and a source select. The reserved bytes are stuffed only while alarm-driven AIS-P is being generated, which is when any of the four alarm inputs is high. A global bypass forwards every byte unchanged. The orderwire byte also has a handshake. A small state machine records a write to the orderwire register and raises a sticky ready status once that value has actually left in an orderwire slot. A mask gates the interrupt.

The handshake machine has two states. In `E2_IDLE` no written value is waiting. In `E2_ARMED` a written value is waiting to be sent. The `WRITE` transition, taken from either state on a register write, goes to `E2_ARMED` and clears the status. The `SENT` transition goes from `E2_ARMED` to `E2_IDLE` when the register value is placed in an orderwire slot and no write arrives in the same cycle. Taking `SENT` sets the status.

Top module: `loh_insert`

## Requirements
- R1: During and directly after reset, `out_byte` is 0x00, `e2_ready` is 0 and `irq` is 0.
- R2: A byte on `in_byte` that falls in no active substitution appears unchanged on `out_byte` exactly one clock later.
- R3: When `slot_s1` is high, `cfg_bypass` is 0 and `cfg_s1_en` is 1, the next output byte is `cfg_s1_value` if `cfg_s1_port` is 0, and `ohp_s1_byte` if `cfg_s1_port` is 1.
- R4: When `slot_s1` is high and `cfg_s1_en` is 0, the received byte passes through unchanged.
- R5: When `slot_e2` is high and `cfg_bypass` is 0, the next output byte is the stored orderwire register value if `cfg_e2_en` is 1 and `cfg_e2_port` is 0. It is `ohp_e2_byte` if `cfg_e2_en` is 1 and `cfg_e2_port` is 1. It is the received byte if `cfg_e2_en` is 0. The register is loaded from `e2_wr_data` when `e2_wr` is 1 and resets to 0x00.
- R6: When `slot_resv` is high and `cfg_bypass` is 0, the next output byte is 0xAA if `cfg_stuff_sel` is 0 and 0x55 if it is 1, provided at least one of `alm_ais_l`, `alm_lof`, `alm_los`, `alm_loc` is high. With no alarm high the received byte passes through.
- R7: When `cfg_bypass` is 1, every byte, whatever slot it falls in, appears unchanged one clock later.
- R8: After a register write, `e2_ready` becomes 1 in the same cycle as the first following orderwire slot that carries the register value appears on `out_byte`. It then stays at 1.
- R9: A one-cycle `e2_stat_clr` clears `e2_ready` unless the status is being set in that cycle, in which case the set wins. An `e2_wr` clears `e2_ready` and re-arms the handshake. A write has priority over an insertion in the same cycle.
- R10: `irq` is 1 exactly when `e2_ready` is 1 and `e2_irq_mask` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_byte | input | 8 | Incoming stream byte |
| slot_s1 | input | 1 | Current byte is the synchronisation status slot |
| slot_e2 | input | 1 | Current byte is the orderwire slot |
| slot_resv | input | 1 | Current byte is a reserved line overhead slot |
| ohp_s1_byte | input | 8 | Synchronisation status byte from the overhead port |
| ohp_e2_byte | input | 8 | Orderwire byte from the overhead port |
| cfg_bypass | input | 1 | Forward all bytes unchanged |
| cfg_s1_en | input | 1 | Enable synchronisation status substitution |
| cfg_s1_port | input | 1 | 1: take it from the overhead port, 0: from cfg_s1_value |
| cfg_s1_value | input | 8 | Configured synchronisation status byte |
| cfg_e2_en | input | 1 | Enable orderwire substitution |
| cfg_e2_port | input | 1 | 1: take it from the overhead port, 0: from the register |
| e2_wr | input | 1 | Write strobe for the orderwire register |
| e2_wr_data | input | 8 | Orderwire register write data |
| e2_stat_clr | input | 1 | Write-one-to-clear for the ready status |
| e2_irq_mask | input | 1 | Mask for the ready interrupt |
| cfg_stuff_sel | input | 1 | Stuff pattern: 0 gives 0xAA, 1 gives 0x55 |
| alm_ais_l | input | 1 | Line AIS alarm |
| alm_lof | input | 1 | Loss of frame alarm |
| alm_los | input | 1 | Loss of signal alarm |
| alm_loc | input | 1 | Loss of clock alarm |
| out_byte | output | 8 | Outgoing stream byte, one-cycle latency |
| e2_ready | output | 1 | Sticky orderwire ready status |
| irq | output | 1 | Masked ready interrupt |

## Verification
The assertions take it that the decoder raises at most one of the three slot strobes in any cycle. A byte cannot be two overhead bytes at once, so the block does not resolve overlap, and the checker states this as an input property. The bench picks at most one slot per cycle from a single random draw, so it never leaves that assumption. Configuration and alarm inputs may change on any cycle. The stimulus changes them randomly between bytes to test that each decision uses only values from the same cycle.

// File: rtl/loh_pkg.sv
package loh_pkg;

    // Source chosen for the byte leaving in the next cycle
    typedef enum logic [2:0] {
        SRC_PASS    = 3'd0,
        SRC_S1_REG  = 3'd1,
        SRC_S1_PORT = 3'd2,
        SRC_E2_REG  = 3'd3,
        SRC_E2_PORT = 3'd4,
        SRC_STUFF   = 3'd5
    } src_e;

    // Orderwire write handshake
    typedef enum logic {
        E2_IDLE  = 1'b0,
        E2_ARMED = 1'b1
    } e2_st_e;

endpackage

// File: rtl/loh_src_sel.sv
module loh_src_sel
    import loh_pkg::*;
(
    input  logic bypass,
    input  logic slot_s1,
    input  logic slot_e2,
    input  logic slot_resv,
    input  logic s1_en,
    input  logic s1_port,
    input  logic e2_en,
    input  logic e2_port,
    input  logic ais_active,
    output src_e sel
);

    always_comb begin
        sel = SRC_PASS;
        if (!bypass) begin
            if (slot_s1 && s1_en) begin
                sel = s1_port ? SRC_S1_PORT : SRC_S1_REG;
            end else if (slot_e2 && e2_en) begin
                sel = e2_port ? SRC_E2_PORT : SRC_E2_REG;
            end else if (slot_resv && ais_active) begin
                sel = SRC_STUFF;
            end
        end
    end

endmodule

// File: rtl/loh_byte_mux.sv
module loh_byte_mux
    import loh_pkg::*;
#(
    parameter int DW = 8
) (
    input  src_e          sel,
    input  logic [DW-1:0] in_byte,
    input  logic [DW-1:0] s1_reg,
    input  logic [DW-1:0] s1_port,
    input  logic [DW-1:0] e2_reg,
    input  logic [DW-1:0] e2_port,
    input  logic          stuff_sel,
    output logic [DW-1:0] byte_o
);

    localparam int HALF = DW / 2;
    localparam logic [DW-1:0] STUFF_HI = {HALF{2'b10}};
    localparam logic [DW-1:0] STUFF_LO = {HALF{2'b01}};

    always_comb begin
        unique case (sel)
            SRC_PASS:    byte_o = in_byte;
            SRC_S1_REG:  byte_o = s1_reg;
            SRC_S1_PORT: byte_o = s1_port;
            SRC_E2_REG:  byte_o = e2_reg;
            SRC_E2_PORT: byte_o = e2_port;
            SRC_STUFF:   byte_o = stuff_sel ? STUFF_LO : STUFF_HI;
            default:     byte_o = in_byte;
        endcase
    end

endmodule

// File: rtl/loh_e2_ctrl.sv
module loh_e2_ctrl
    import loh_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [DW-1:0] wr_data,
    input  logic          clr,
    input  logic          inserted,
    output logic [DW-1:0] e2_value,
    output logic          ready
);

    e2_st_e state_q, state_d;
    logic   set_ready;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= E2_IDLE;
        else        state_q <= state_d;
    end

    // Next state and transition outputs
    always_comb begin
        state_d   = state_q;
        set_ready = 1'b0;
        unique case (state_q)
            E2_IDLE: begin
                if (wr) state_d = E2_ARMED;
            end
            E2_ARMED: begin
                if (wr) begin
                    state_d = E2_ARMED;
                end else if (inserted) begin
                    state_d   = E2_IDLE;
                    set_ready = 1'b1;
                end
            end
            default: state_d = E2_IDLE;
        endcase
    end

    // Register value and sticky status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e2_value <= '0;
            ready    <= 1'b0;
        end else begin
            if (wr) e2_value <= wr_data;
            if (wr)             ready <= 1'b0;
            else if (set_ready) ready <= 1'b1;
            else if (clr)       ready <= 1'b0;
        end
    end

endmodule

// File: rtl/loh_insert.sv
module loh_insert
    import loh_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] in_byte,
    input  logic          slot_s1,
    input  logic          slot_e2,
    input  logic          slot_resv,
    input  logic [DW-1:0] ohp_s1_byte,
    input  logic [DW-1:0] ohp_e2_byte,
    input  logic          cfg_bypass,
    input  logic          cfg_s1_en,
    input  logic          cfg_s1_port,
    input  logic [DW-1:0] cfg_s1_value,
    input  logic          cfg_e2_en,
    input  logic          cfg_e2_port,
    input  logic          e2_wr,
    input  logic [DW-1:0] e2_wr_data,
    input  logic          e2_stat_clr,
    input  logic          e2_irq_mask,
    input  logic          cfg_stuff_sel,
    input  logic          alm_ais_l,
    input  logic          alm_lof,
    input  logic          alm_los,
    input  logic          alm_loc,
    output logic [DW-1:0] out_byte,
    output logic          e2_ready,
    output logic          irq
);

    src_e          sel;
    logic          ais_active;
    logic [DW-1:0] e2_value;
    logic [DW-1:0] next_byte;

    assign ais_active = alm_ais_l | alm_lof | alm_los | alm_loc;

    loh_src_sel u_sel (
        .bypass     (cfg_bypass),
        .slot_s1    (slot_s1),
        .slot_e2    (slot_e2),
        .slot_resv  (slot_resv),
        .s1_en      (cfg_s1_en),
        .s1_port    (cfg_s1_port),
        .e2_en      (cfg_e2_en),
        .e2_port    (cfg_e2_port),
        .ais_active (ais_active),
        .sel        (sel)
    );

    loh_e2_ctrl #(.DW(DW)) u_e2 (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (e2_wr),
        .wr_data  (e2_wr_data),
        .clr      (e2_stat_clr),
        .inserted (sel == SRC_E2_REG),
        .e2_value (e2_value),
        .ready    (e2_ready)
    );

    loh_byte_mux #(.DW(DW)) u_mux (
        .sel       (sel),
        .in_byte   (in_byte),
        .s1_reg    (cfg_s1_value),
        .s1_port   (ohp_s1_byte),
        .e2_reg    (e2_value),
        .e2_port   (ohp_e2_byte),
        .stuff_sel (cfg_stuff_sel),
        .byte_o    (next_byte)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) out_byte <= '0;
        else        out_byte <= next_byte;
    end

    assign irq = e2_ready & ~e2_irq_mask;

endmodule

// File: rtl/loh_insert_chk.sv
module loh_insert_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [DW-1:0] in_byte,
    input logic          slot_s1,
    input logic          slot_e2,
    input logic          slot_resv,
    input logic          cfg_bypass,
    input logic          cfg_s1_en,
    input logic          cfg_s1_port,
    input logic [DW-1:0] cfg_s1_value,
    input logic          e2_wr,
    input logic          e2_stat_clr,
    input logic          e2_irq_mask,
    input logic          cfg_stuff_sel,
    input logic          alm_ais_l,
    input logic          alm_lof,
    input logic          alm_los,
    input logic          alm_loc,
    input logic [DW-1:0] out_byte,
    input logic          e2_ready,
    input logic          irq
);

    localparam logic [DW-1:0] PAT_HI = {(DW/2){2'b10}};
    localparam logic [DW-1:0] PAT_LO = {(DW/2){2'b01}};

    logic live_q;
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    // R2 (input assumption: one slot at a time)
    slot_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({slot_s1, slot_e2, slot_resv}));

    // R2
    plain_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && $past(!slot_s1 && !slot_e2 && !slot_resv) |-> out_byte == $past(in_byte));

    // R7
    bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && $past(cfg_bypass) |-> out_byte == $past(in_byte));

    // R3
    s1_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && $past(slot_s1 && cfg_s1_en && !cfg_s1_port && !cfg_bypass)
        |-> out_byte == $past(cfg_s1_value));

    // R6
    stuff_pat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && $past(slot_resv && !cfg_bypass && (alm_ais_l || alm_lof || alm_los || alm_loc))
        |-> out_byte == ($past(cfg_stuff_sel) ? PAT_LO : PAT_HI));

    // R9
    ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && $past(e2_ready && !e2_stat_clr && !e2_wr) |-> e2_ready);

    // R9
    wr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && $past(e2_wr) |-> !e2_ready);

    // R10
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        e2_irq_mask |-> !irq);

    // R10
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (e2_ready && !e2_irq_mask) |-> irq);

endmodule

bind loh_insert loh_insert_chk #(.DW(DW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_byte       (in_byte),
    .slot_s1       (slot_s1),
    .slot_e2       (slot_e2),
    .slot_resv     (slot_resv),
    .cfg_bypass    (cfg_bypass),
    .cfg_s1_en     (cfg_s1_en),
    .cfg_s1_port   (cfg_s1_port),
    .cfg_s1_value  (cfg_s1_value),
    .e2_wr         (e2_wr),
    .e2_stat_clr   (e2_stat_clr),
    .e2_irq_mask   (e2_irq_mask),
    .cfg_stuff_sel (cfg_stuff_sel),
    .alm_ais_l     (alm_ais_l),
    .alm_lof       (alm_lof),
    .alm_los       (alm_los),
    .alm_loc       (alm_loc),
    .out_byte      (out_byte),
    .e2_ready      (e2_ready),
    .irq           (irq)
);

// File: tb/loh_insert_tb.sv
module loh_insert_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int RUN_CYCLES = 4000;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_byte = '0;
    logic       slot_s1 = 1'b0, slot_e2 = 1'b0, slot_resv = 1'b0;
    logic [7:0] ohp_s1_byte = '0, ohp_e2_byte = '0;
    logic       cfg_bypass = 1'b0, cfg_s1_en = 1'b0, cfg_s1_port = 1'b0;
    logic [7:0] cfg_s1_value = '0;
    logic       cfg_e2_en = 1'b0, cfg_e2_port = 1'b0;
    logic       e2_wr = 1'b0;
    logic [7:0] e2_wr_data = '0;
    logic       e2_stat_clr = 1'b0, e2_irq_mask = 1'b0, cfg_stuff_sel = 1'b0;
    logic       alm_ais_l = 1'b0, alm_lof = 1'b0, alm_los = 1'b0, alm_loc = 1'b0;
    wire  [7:0] out_byte;
    wire        e2_ready;
    wire        irq;

    int checks = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    // reference model state
    logic [7:0] m_out = '0;
    logic [7:0] m_e2 = '0;
    bit         m_pend = 1'b0;
    bit         m_stat = 1'b0;
    string      m_tag = "R1";
    string      m_stag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    loh_insert dut_i (
        .clk(clk), .rst_n(rst_n), .in_byte(in_byte),
        .slot_s1(slot_s1), .slot_e2(slot_e2), .slot_resv(slot_resv),
        .ohp_s1_byte(ohp_s1_byte), .ohp_e2_byte(ohp_e2_byte),
        .cfg_bypass(cfg_bypass), .cfg_s1_en(cfg_s1_en), .cfg_s1_port(cfg_s1_port),
        .cfg_s1_value(cfg_s1_value), .cfg_e2_en(cfg_e2_en), .cfg_e2_port(cfg_e2_port),
        .e2_wr(e2_wr), .e2_wr_data(e2_wr_data), .e2_stat_clr(e2_stat_clr),
        .e2_irq_mask(e2_irq_mask), .cfg_stuff_sel(cfg_stuff_sel),
        .alm_ais_l(alm_ais_l), .alm_lof(alm_lof), .alm_los(alm_los), .alm_loc(alm_loc),
        .out_byte(out_byte), .e2_ready(e2_ready), .irq(irq)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    endtask

    // Behavioural reference, compared every clock
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_out = '0; m_e2 = '0; m_pend = 1'b0; m_stat = 1'b0;
            m_tag = "R1"; m_stag = "R1";
        end else begin
            bit alarm;
            bit e2_from_reg;
            alarm = alm_ais_l || alm_lof || alm_los || alm_loc;
            e2_from_reg = 1'b0;
            m_stag = "R8";
            if (cfg_bypass) begin
                m_out = in_byte; m_tag = "R7";
            end else if (slot_s1) begin
                if (cfg_s1_en) begin
                    m_out = cfg_s1_port ? ohp_s1_byte : cfg_s1_value; m_tag = "R3";
                end else begin
                    m_out = in_byte; m_tag = "R4";
                end
            end else if (slot_e2) begin
                m_tag = "R5";
                if (!cfg_e2_en)       m_out = in_byte;
                else if (cfg_e2_port) m_out = ohp_e2_byte;
                else begin
                    m_out = m_e2; e2_from_reg = 1'b1;
                end
            end else if (slot_resv) begin
                m_tag = "R6";
                m_out = !alarm ? in_byte : (cfg_stuff_sel ? 8'h55 : 8'hAA);
            end else begin
                m_out = in_byte; m_tag = "R2";
            end
            if (e2_wr) begin
                m_e2 = e2_wr_data; m_pend = 1'b1; m_stat = 1'b0; m_stag = "R9";
            end else if (m_pend && e2_from_reg) begin
                m_pend = 1'b0; m_stat = 1'b1; m_stag = "R8";
            end else if (e2_stat_clr) begin
                m_stat = 1'b0; m_stag = "R9";
            end
        end
        #1;
        check(m_tag, out_byte, m_out);
        check(m_stag, {7'd0, e2_ready}, {7'd0, m_stat});
        check(rst_n ? "R10" : "R1", {7'd0, irq}, {7'd0, m_stat & ~e2_irq_mask});
    end

    // Stimulus, driven on the falling edge
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // directed R8: write, then send in an orderwire slot from the register
        @(negedge clk);
        e2_wr = 1'b1; e2_wr_data = 8'h3C;
        @(negedge clk);
        e2_wr = 1'b0; cfg_e2_en = 1'b1; cfg_e2_port = 1'b0; slot_e2 = 1'b1; in_byte = 8'h11;
        @(negedge clk);
        slot_e2 = 1'b0; e2_stat_clr = 1'b1;
        @(negedge clk);
        e2_stat_clr = 1'b0;
        // random phase
        for (int i = 0; i < RUN_CYCLES; i++) begin
            @(negedge clk);
            begin
                int s;
                s = $urandom_range(0, 5);
                slot_s1   = (s == 0);
                slot_e2   = (s == 1);
                slot_resv = (s == 2);
            end
            in_byte       = 8'($urandom);
            ohp_s1_byte   = 8'($urandom);
            ohp_e2_byte   = 8'($urandom);
            cfg_s1_value  = 8'($urandom);
            e2_wr_data    = 8'($urandom);
            cfg_bypass    = ($urandom_range(0, 9) == 0);
            cfg_s1_en     = ($urandom_range(0, 3) != 0);
            cfg_s1_port   = $urandom_range(0, 1) == 1;
            cfg_e2_en     = ($urandom_range(0, 3) != 0);
            cfg_e2_port   = ($urandom_range(0, 2) == 0);
            e2_wr         = ($urandom_range(0, 15) == 0);
            e2_stat_clr   = ($urandom_range(0, 15) == 0);
            if ($urandom_range(0, 31) == 0) e2_irq_mask = ~e2_irq_mask;
            cfg_stuff_sel = $urandom_range(0, 1) == 1;
            alm_ais_l     = ($urandom_range(0, 5) == 0);
            alm_lof       = ($urandom_range(0, 5) == 0);
            alm_los       = ($urandom_range(0, 5) == 0);
            alm_loc       = ($urandom_range(0, 5) == 0);
        end
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        finish_run();
    end

    // Watchdog
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

endmodule